// File: doc/BRIEF.md
# 1-Wire Slave Memory Command Unit

This unit is the command layer that sits behind a 1-Wire slave bit front end. It sees three kinds of events, each a single-cycle strobe: a bus reset, a write slot carrying one bit, and a read slot. It answers each read slot with the bit it presents on `rd_bit`. Through this bit stream it reaches a 256-byte address space. The low bytes of that space are held in a volatile shadow register file, and a second register file models the nonvolatile cells that sit under the shadow. Addresses 00h–07h hold a 64-bit challenge, 08h–1Bh hold a 160-bit expected MAC, and 1Ch–1Dh hold a 16-bit configuration word. Everything from 1Eh upward is reserved.

Every transaction starts with a bus reset, then the skip-address code, then one function code. Read and write take a start address and then stream bytes least significant bit first. The address steps after every completed byte and wraps from FFh to 00h. Copy moves the whole shadow into the nonvolatile model once a programming pulse of sufficient width ends. Recall loads the nonvolatile model back into the shadow. A two-bit lock field in the configuration word, combined with a copy, seals the array for good.

Top module: `ow_mem_cmd_unit`

## Requirements
- R1: After a bus reset the first byte must be CCh. Any other first byte makes the unit ignore all slots until the next bus reset: read slots return 1 and writes have no effect.
- R2: The second byte selects the function: 69h read, 6Ch write, 48h copy, B8h recall. Any other code is ignored until the next bus reset. Read and write then take an 8-bit start address. Every byte on the wire, address and data alike, travels least significant bit first.
- R3: The address advances by one after each complete data byte, in both read and write, and wraps from FFh to 00h. Streaming continues until a bus reset.
- R4: Write changes only the shadow. The nonvolatile model stays unchanged until a copy.
- R5: A data byte cut short by a bus reset is discarded. The shadow byte at that address keeps its old value.
- R6: Writes to addresses 1Eh–FFh are ignored, and reads of those addresses return FFh.
- R7: While a copy is pending, `busy` is 1 and read slots return 0. Once the copy completes, `busy` is 0 and read slots return 1.
- R8: A copy completes at the cycle where `vpp` is first seen low after having been high for at least MIN_PULSE consecutive clock cycles. A shorter pulse leaves the copy pending.
- R9: A bus reset during a pending copy aborts it, and the nonvolatile model keeps its previous contents.
- R10: Recall replaces the whole shadow with the nonvolatile model.
- R11: The lock field sits at bits 3:2 of address 1Dh. When the code 10b is present there as a copy completes, `locked` becomes 1 permanently, bit 7 of address 1Dh reads as 1, and all later writes are ignored. The other codes do not lock.
- R12: After the synchronous reset `rd_bit` is 1, `busy` and `locked` are 0, both register files hold zeros, and the unit waits for a bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ow_reset | input | 1 | Strobe: bus reset pulse seen by the front end |
| wr_slot | input | 1 | Strobe: write slot received |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_slot | input | 1 | Strobe: read slot served; the unit advances to the next bit |
| rd_bit | output | 1 | Bit to return in the next read slot |
| vpp | input | 1 | Programming pulse level |
| busy | output | 1 | Copy pending |
| locked | output | 1 | Array permanently locked |

## Verification
Read-back follows write streams of ascending patterns across the whole real region. A start near FFh separates correct wraparound from a stop or a jump into the reserved area. A wrong first byte and an unknown function code separate gating from decoding, and a byte cut off mid-stream shows whether partial data leaks into the shadow. Copy is tried with a short pulse, a long pulse, and a long pulse interrupted by a bus reset, and each result is read through a recall. This separates width qualification, completion and abort. Lock codes 01b and 10b separate arming from an ordinary copy.

// File: rtl/ow_mem_pkg.sv
package ow_mem_pkg;

    localparam int ADDR_W = 8;

    localparam logic [7:0] CODE_SKIP   = 8'hCC;
    localparam logic [7:0] CODE_READ   = 8'h69;
    localparam logic [7:0] CODE_WRITE  = 8'h6C;
    localparam logic [7:0] CODE_COPY   = 8'h48;
    localparam logic [7:0] CODE_RECALL = 8'hB8;

    localparam logic [1:0] LOCK_ARM_CODE = 2'b10;
    localparam logic [7:0] RESERVED_READ = 8'hFF;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_NET,
        ST_FUNC,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_COPY,
        ST_DONE
    } cu_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    function automatic logic addr_in_store(input logic [ADDR_W-1:0] a, input int unsigned n);
        return 32'(a) < n;
    endfunction

endpackage

// File: rtl/ow_byte_asm.sv
module ow_byte_asm
    import ow_mem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     wr_slot,
    input  logic     wr_bit,
    input  logic     rd_slot,
    output logic [2:0] bit_idx,
    output rx_byte_t rx_byte,
    output logic     rd_byte_done
);
    logic [7:0] shift_q;
    logic [2:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (wr_slot) begin
            shift_q <= {wr_bit, shift_q[7:1]};
            idx_q   <= idx_q + 3'd1;
        end else if (rd_slot) begin
            idx_q   <= idx_q + 3'd1;
        end
    end

    assign bit_idx      = idx_q;
    assign rx_byte.valid = wr_slot && !clear && (idx_q == 3'd7);
    assign rx_byte.data  = {wr_bit, shift_q[7:1]};
    assign rd_byte_done  = rd_slot && !wr_slot && !clear && (idx_q == 3'd7);
endmodule

// File: rtl/ow_prog_timer.sv
module ow_prog_timer #(
    parameter int MIN_PULSE = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic vpp,
    output logic fall_ok
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

    logic [CNT_W-1:0] hi_cnt_q;
    logic             vpp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q <= '0;
            vpp_q    <= 1'b0;
        end else begin
            vpp_q <= vpp;
            if (!vpp)
                hi_cnt_q <= '0;
            else if (hi_cnt_q != CNT_MAX)
                hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign fall_ok = vpp_q && !vpp && (hi_cnt_q == CNT_MAX);
endmodule

// File: rtl/ow_store.sv
module ow_store
    import ow_mem_pkg::*;
#(
    parameter int NUM_BYTES = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              copy_en,
    input  logic              recall_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [1:0]        lock_field
);
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    logic [NUM_BYTES-1:0][7:0] sh_view;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cell
        logic [7:0] sh_r;
        logic [7:0] nv_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_r <= '0;
                nv_r <= '0;
            end else begin
                if (recall_en)
                    sh_r <= nv_r;
                else if (wr_en && wr_addr == 8'(g))
                    sh_r <= wr_data;
                if (copy_en)
                    nv_r <= sh_r;
            end
        end

        assign sh_view[g] = sh_r;
    end

    assign rd_data    = addr_in_store(rd_addr, NUM_BYTES) ? sh_view[rd_addr[IDX_W-1:0]]
                                                          : RESERVED_READ;
    assign lock_field = sh_view[NUM_BYTES-1][3:2];
endmodule

// File: rtl/ow_mem_cmd_unit.sv
module ow_mem_cmd_unit
    import ow_mem_pkg::*;
#(
    parameter int NUM_BYTES = 30,
    parameter int MIN_PULSE = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic ow_reset,
    input  logic wr_slot,
    input  logic wr_bit,
    input  logic rd_slot,
    output logic rd_bit,
    input  logic vpp,
    output logic busy,
    output logic locked
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_BYTES - 1);

    cu_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_wr_q;
    logic              locked_q;

    rx_byte_t          rx;
    logic [2:0]        bit_idx;
    logic              rd_done;
    logic              fall_ok;
    logic [7:0]        store_byte;
    logic [7:0]        view_byte;
    logic [1:0]        lock_field;
    logic              wr_en, copy_en, recall_en;

    ow_byte_asm u_asm (
        .clk(clk), .rst(rst), .clear(ow_reset),
        .wr_slot(wr_slot), .wr_bit(wr_bit), .rd_slot(rd_slot),
        .bit_idx(bit_idx), .rx_byte(rx), .rd_byte_done(rd_done)
    );

    ow_prog_timer #(.MIN_PULSE(MIN_PULSE)) u_timer (
        .clk(clk), .rst(rst), .vpp(vpp), .fall_ok(fall_ok)
    );

    ow_store #(.NUM_BYTES(NUM_BYTES)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(addr_q), .wr_data(rx.data),
        .copy_en(copy_en), .recall_en(recall_en),
        .rd_addr(addr_q), .rd_data(store_byte), .lock_field(lock_field)
    );

    assign wr_en     = !ow_reset && state_q == ST_WRITE && rx.valid && !locked_q
                       && addr_in_store(addr_q, NUM_BYTES);
    assign copy_en   = !ow_reset && state_q == ST_COPY && fall_ok;
    assign recall_en = !ow_reset && state_q == ST_FUNC && rx.valid && rx.data == CODE_RECALL;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_WAIT;
            addr_q   <= '0;
            is_wr_q  <= 1'b0;
            locked_q <= 1'b0;
        end else if (ow_reset) begin
            state_q <= ST_NET;
        end else begin
            unique case (state_q)
                ST_NET:
                    if (rx.valid)
                        state_q <= (rx.data == CODE_SKIP) ? ST_FUNC : ST_WAIT;
                ST_FUNC:
                    if (rx.valid) begin
                        unique case (rx.data)
                            CODE_READ:  begin is_wr_q <= 1'b0; state_q <= ST_ADDR; end
                            CODE_WRITE: begin is_wr_q <= 1'b1; state_q <= ST_ADDR; end
                            CODE_COPY:  state_q <= ST_COPY;
                            default:    state_q <= ST_WAIT;
                        endcase
                    end
                ST_ADDR:
                    if (rx.valid) begin
                        addr_q  <= rx.data;
                        state_q <= is_wr_q ? ST_WRITE : ST_READ;
                    end
                ST_READ:
                    if (rd_done) addr_q <= addr_q + 1'b1;
                ST_WRITE:
                    if (rx.valid) addr_q <= addr_q + 1'b1;
                ST_COPY:
                    if (fall_ok) begin
                        state_q <= ST_DONE;
                        if (lock_field == LOCK_ARM_CODE) locked_q <= 1'b1;
                    end
                default: ;
            endcase
        end
    end

    always_comb begin
        view_byte = store_byte;
        if (addr_q == LOCK_ADDR) view_byte[7] = locked_q;
        unique case (state_q)
            ST_READ: rd_bit = view_byte[bit_idx];
            ST_COPY: rd_bit = 1'b0;
            default: rd_bit = 1'b1;
        endcase
    end

    assign busy   = (state_q == ST_COPY);
    assign locked = locked_q;
endmodule

// File: rtl/ow_mem_cmd_unit_chk.sv
module ow_mem_cmd_unit_chk #(
    parameter int MIN_PULSE = 20
) (
    input logic clk,
    input logic rst,
    input logic ow_reset,
    input logic vpp,
    input logic rd_bit,
    input logic busy,
    input logic locked
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic [CNT_W-1:0] hi_cnt;
    logic             vpp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            vpp_d  <= 1'b0;
        end else begin
            vpp_d <= vpp;
            if (!vpp) hi_cnt <= '0;
            else if (32'(hi_cnt) < MIN_PULSE) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_reset_state_R12: assert property (@(posedge clk)
        rst |=> (!busy && !locked && rd_bit));

    assert_copy_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_bit);

    assert_short_pulse_keeps_copy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !ow_reset && vpp_d && !vpp && 32'(hi_cnt) < MIN_PULSE) |=> busy);

    assert_reset_aborts_copy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && ow_reset) |=> !busy);

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    assert_lock_from_copy_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(busy));
endmodule

bind ow_mem_cmd_unit ow_mem_cmd_unit_chk #(.MIN_PULSE(MIN_PULSE)) u_chk (
    .clk(clk), .rst(rst), .ow_reset(ow_reset), .vpp(vpp),
    .rd_bit(rd_bit), .busy(busy), .locked(locked)
);

// File: tb/ow_mem_cmd_unit_bench.sv
module ow_mem_cmd_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 30;
    localparam int MINP = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ow_reset = 1'b0, wr_slot = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0, vpp = 1'b0;
    logic rd_bit, busy, locked;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] m_sh [NB];
    logic [7:0] m_nv [NB];
    bit m_lock = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ow_mem_cmd_unit #(.NUM_BYTES(NB), .MIN_PULSE(MINP)) u_ow_mem_cmd_unit (
        .clk(clk), .rst(rst), .ow_reset(ow_reset), .wr_slot(wr_slot), .wr_bit(wr_bit),
        .rd_slot(rd_slot), .rd_bit(rd_bit), .vpp(vpp), .busy(busy), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if (a >= NB) return 8'hFF;
        if (a == NB - 1) return {m_lock, m_sh[a][6:0]};
        return m_sh[a];
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic bus_reset();
        ow_reset = 1'b1; tick(); ow_reset = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        wr_slot = 1'b1; wr_bit = b; tick(); wr_slot = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic read_bit(output logic b);
        b = rd_bit; rd_slot = 1'b1; tick(); rd_slot = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic v;
            read_bit(v);
            b[i] = v;
        end
    endtask

    task automatic write_seq(input logic [7:0] start, input int n, input logic [7:0] seed);
        logic [7:0] a = start;
        bus_reset(); send_byte(8'hCC); send_byte(8'h6C); send_byte(start);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = seed + 8'(i * 37);
            send_byte(d);
            if (int'(a) < NB && !m_lock) m_sh[a] = d;
            a = a + 8'd1;
        end
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d);
        bus_reset(); send_byte(8'hCC); send_byte(8'h6C); send_byte(a); send_byte(d);
        if (int'(a) < NB && !m_lock) m_sh[a] = d;
    endtask

    task automatic read_check(input string req, input logic [7:0] start, input int n);
        logic [7:0] a = start;
        bus_reset(); send_byte(8'hCC); send_byte(8'h69); send_byte(start);
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            read_byte(got);
            chk(req, 32'(got), 32'(exp_rd(int'(a))));
            a = a + 8'd1;
        end
    endtask

    task automatic recall();
        bus_reset(); send_byte(8'hCC); send_byte(8'hB8); tick();
        for (int i = 0; i < NB; i++) m_sh[i] = m_nv[i];
    endtask

    task automatic full_copy();
        bus_reset(); send_byte(8'hCC); send_byte(8'h48);
        vpp = 1'b1; repeat (MINP + 5) tick(); vpp = 1'b0; tick();
        for (int i = 0; i < NB; i++) m_nv[i] = m_sh[i];
        if (m_sh[NB-1][3:2] == 2'b10) m_lock = 1'b1;
    endtask

    task automatic t_reset_state();
        chk("R12 rd_bit", 32'(rd_bit), 32'd1);
        chk("R12 busy", 32'(busy), 32'd0);
        chk("R12 locked", 32'(locked), 32'd0);
        read_check("R12 zero shadow", 8'h00, 4);
    endtask

    task automatic t_stream();
        write_seq(8'h00, NB, 8'h11);
        write_one(8'(NB - 1), 8'h01);
        read_check("R2 R3 stream", 8'h00, NB);
    endtask

    task automatic t_wrap_reserved();
        write_seq(8'hFD, 5, 8'h40);
        read_check("R3 wrap", 8'hFE, 4);
        write_one(8'h1E, 8'h5A);
        read_check("R6 reserved", 8'h1C, 4);
    endtask

    task automatic t_bad_codes();
        bus_reset(); send_byte(8'h33); send_byte(8'h6C); send_byte(8'h00); send_byte(8'h5A);
        chk("R1 idle rd_bit", 32'(rd_bit), 32'd1);
        read_check("R1 bad net code", 8'h00, 1);
        bus_reset(); send_byte(8'hCC); send_byte(8'hAA); send_byte(8'h00); send_byte(8'h5A);
        read_check("R2 unknown function", 8'h00, 1);
    endtask

    task automatic t_partial();
        bus_reset(); send_byte(8'hCC); send_byte(8'h6C); send_byte(8'h05);
        send_byte(8'hC3); m_sh[5] = 8'hC3;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_reset();
        read_check("R5 partial byte", 8'h05, 2);
    endtask

    task automatic t_shadow_only();
        write_one(8'h03, 8'hEE);
        recall();
        read_check("R4 R10 nv untouched", 8'h00, 6);
    endtask

    task automatic t_copy();
        logic b;
        write_seq(8'h00, 8, 8'h31);
        write_one(8'(NB - 1), 8'h01);
        bus_reset(); send_byte(8'hCC); send_byte(8'h48);
        chk("R7 busy pending", 32'(busy), 32'd1);
        read_bit(b); chk("R7 read slot 0", 32'(b), 32'd0);
        vpp = 1'b1; repeat (5) tick(); vpp = 1'b0; tick();
        chk("R8 short pulse", 32'(busy), 32'd1);
        vpp = 1'b1; repeat (MINP + 5) tick(); vpp = 1'b0; tick();
        chk("R7 copy done", 32'(busy), 32'd0);
        read_bit(b); chk("R7 read slot 1", 32'(b), 32'd1);
        for (int i = 0; i < NB; i++) m_nv[i] = m_sh[i];
        write_one(8'h00, 8'h77);
        recall();
        read_check("R10 recall", 8'h00, NB);
    endtask

    task automatic t_abort();
        write_one(8'h00, 8'h99);
        bus_reset(); send_byte(8'hCC); send_byte(8'h48);
        vpp = 1'b1; repeat (MINP + 5) tick();
        bus_reset();
        chk("R9 abort", 32'(busy), 32'd0);
        vpp = 1'b0; tick();
        chk("R9 late fall", 32'(busy), 32'd0);
        recall();
        read_check("R9 nv kept", 8'h00, 1);
    endtask

    task automatic t_lock();
        write_one(8'(NB - 1), 8'h04);
        full_copy();
        chk("R11 code 01 no lock", 32'(locked), 32'd0);
        write_one(8'(NB - 1), 8'h08);
        full_copy();
        chk("R11 locked", 32'(locked), 32'd1);
        read_check("R11 lock flag bit", 8'(NB - 1), 1);
        write_one(8'h00, 8'h55);
        read_check("R11 write ignored", 8'h00, 1);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_sh[i] = '0; m_nv[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset_state();
        t_stream();
        t_wrap_reserved();
        t_bad_codes();
        t_partial();
        t_shadow_only();
        t_copy();
        t_abort();
        t_lock();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule